// File: doc/BRIEF.md
# Fractional Crystal Prescaler Chain

This block turns a 32.768 kHz oscillator, presented to the synchronous system clock as a one-cycle enable, into the 10 Hz setting tick that advances a calendar's time registers. The chain has three stages. A pulse-swallowing stage removes one enable out of every sixteen, giving a 30.720 kHz rate. A nine-bit binary counter divides that by 512 to 60 Hz. A three-stage twisted-ring (Johnson) counter divides by six to reach 10 Hz. A level output marks the final 60 Hz period of each 10 Hz cycle. A one-cycle strobe marks the end of that period, and the time registers step on that strobe.

A stop input holds every stage at zero, so a release restarts the chain from a known phase. A test input freezes the chain. While test is active and stop is low, every oscillator enable becomes a setting tick, which lets the time registers be clocked quickly. In test mode, when no interrupt is armed, the interrupt pin carries the raw oscillator level instead of the interrupt timer's output.

Top module: `xtal_prescaler`

## Requirements
- R1: After reset, `six_phase` is 000, `set_pulse` is 0 and `set_tick` is 0.
- R2: In normal running (stop and test low), exactly 10 setting ticks occur in every 32768 oscillator enables counted from a clear. Numbering the enables from 1, enable k is swallowed when k is a multiple of 16.
- R3: Let p be the number of enables that passed the swallow stage since the last clear. `six_phase` advances by one step each time p reaches a multiple of 512, and changes at no other time.
- R4: `six_phase` steps through 000, 001, 011, 111, 110, 100 and then back to 000. Any state outside this ring is replaced by 000 at its next step.
- R5: `set_tick` is high, combinationally, during the enable cycle that moves `six_phase` from 100 to 000. This happens when p reaches a multiple of 3072. `set_pulse` is high exactly while `six_phase` is 100 in normal running.
- R6: While `clk_stop` is high, all stages are cleared and held, so `six_phase` reads 000. No tick and no pulse occur. After release, tick timing restarts as it does after reset.
- R7: With `test_mode` high and `clk_stop` low, `set_tick` equals `osc_en` and the divider chain stays cleared. With `test_mode` and `clk_stop` both high, no tick occurs.
- R8: `irq_pin_n` equals `osc_lvl` when `test_mode` is high and `irq_armed` is low. Otherwise it equals `irq_timer_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | One-cycle enable per oscillator period |
| osc_lvl | input | 1 | Raw oscillator level for test routing |
| clk_stop | input | 1 | Holds the chain cleared and blocks ticks |
| test_mode | input | 1 | Freezes the chain and enables fast ticking |
| irq_armed | input | 1 | An interrupt delay is programmed |
| irq_timer_n | input | 1 | Active-low interrupt from the interrupt timer |
| set_tick | output | 1 | Strobe that steps the time registers |
| set_pulse | output | 1 | Level high during the last 60 Hz period of each 10 Hz cycle |
| six_phase | output | JSTAGES | Johnson counter state |
| irq_pin_n | output | 1 | Interrupt pin level |

## Verification
The bench builds the block with its default parameters: drop one enable in 16, a 9-bit binary stage and 3 Johnson stages. These are the real ratios, so a full 32768-enable run fits easily in the cycle budget. Every enable of that run is checked against an arithmetic model of the swallowed count. That brings every swallow point, every 512-boundary phase step, every 100-to-000 tick and all six ring states within reach. The bench also checks gapped enables, a mid-chain stop and restart, both test-mode sub-cases, and all routing combinations of the interrupt pin.

// File: rtl/xtal_prescaler_pkg.sv
package xtal_prescaler_pkg;

  // Next state of a twisted-ring counter, with the illegal states folded to zero.
  function automatic logic [7:0] ring_next(input logic [7:0] q, input int unsigned w);
    logic [7:0] n;
    n = '0;
    if (!ring_legal(q, w)) return '0;
    for (int i = w - 1; i > 0; i--) n[i] = q[i-1];
    n[0] = ~q[w-1];
    return n;
  endfunction

  // Legal ring states have at most one bit-to-bit change in the linear word.
  function automatic logic ring_legal(input logic [7:0] q, input int unsigned w);
    int unsigned changes;
    changes = 0;
    for (int i = 1; i < w; i++) if (q[i] != q[i-1]) changes++;
    return changes <= 1;
  endfunction

endpackage

// File: rtl/xp_swallow.sv
module xp_swallow #(
  parameter int unsigned DROP_EVERY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en_in,
  output logic en_out
);
  localparam int unsigned CW = $clog2(DROP_EVERY);
  localparam logic [CW-1:0] LAST = CW'(DROP_EVERY - 1);

  logic [CW-1:0] cnt;
  logic          drop_now;

  assign drop_now = en_in && (cnt == LAST);
  assign en_out   = en_in && !drop_now;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  cnt <= '0;
    else if (en_in)     cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  a_r2_no_invented_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    en_out |-> en_in);
  a_r2_drop_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (en_in && cnt == LAST) |-> !en_out);
endmodule

// File: rtl/xp_binary.sv
module xp_binary #(
  parameter int unsigned BIN_W = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en_in,
  output logic carry
);
  logic [BIN_W-1:0] cnt;

  assign carry = en_in && (&cnt);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (en_in)    cnt <= cnt + 1'b1;
  end

  a_r3_carry_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    carry |-> en_in);
  a_r3_carry_wraps: assert property (@(posedge clk) disable iff (!rst_n || clr)
    carry |=> (cnt == '0));
endmodule

// File: rtl/xp_johnson.sv
module xp_johnson
  import xtal_prescaler_pkg::*;
#(
  parameter int unsigned JSTAGES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               step,
  output logic [JSTAGES-1:0] q,
  output logic               at_last
);
  localparam logic [JSTAGES-1:0] LAST_STATE = {1'b1, {(JSTAGES-1){1'b0}}};

  logic [7:0] nxt_w;

  assign nxt_w   = ring_next(8'(q), JSTAGES);
  assign at_last = (q == LAST_STATE);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) q <= '0;
    else if (step)     q <= nxt_w[JSTAGES-1:0];
  end

  a_r4_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n || clr)
    !step |=> $stable(q));
  a_r4_one_bit_moves: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (step && ring_legal(8'(q), JSTAGES)) |=> ($countones(q ^ $past(q)) == 1));
endmodule

// File: rtl/xtal_prescaler.sv
module xtal_prescaler #(
  parameter int unsigned DROP_EVERY = 16,
  parameter int unsigned BIN_W      = 9,
  parameter int unsigned JSTAGES    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               osc_en,
  input  logic               osc_lvl,
  input  logic               clk_stop,
  input  logic               test_mode,
  input  logic               irq_armed,
  input  logic               irq_timer_n,
  output logic               set_tick,
  output logic               set_pulse,
  output logic [JSTAGES-1:0] six_phase,
  output logic               irq_pin_n
);
  logic run;
  logic chain_clr;
  logic en_30k;
  logic en_60;
  logic ring_last;
  logic div_tick;
  logic fast_tick;

  assign run       = !clk_stop && !test_mode;
  assign chain_clr = !run;

  xp_swallow #(.DROP_EVERY(DROP_EVERY)) u_swallow (
    .clk(clk), .rst_n(rst_n), .clr(chain_clr),
    .en_in(osc_en && run), .en_out(en_30k));

  xp_binary #(.BIN_W(BIN_W)) u_binary (
    .clk(clk), .rst_n(rst_n), .clr(chain_clr),
    .en_in(en_30k), .carry(en_60));

  xp_johnson #(.JSTAGES(JSTAGES)) u_johnson (
    .clk(clk), .rst_n(rst_n), .clr(chain_clr),
    .step(en_60), .q(six_phase), .at_last(ring_last));

  assign div_tick  = en_60 && ring_last;
  assign fast_tick = test_mode && !clk_stop && osc_en;
  assign set_tick  = div_tick || fast_tick;
  assign set_pulse = run && ring_last;
  assign irq_pin_n = (test_mode && !irq_armed) ? osc_lvl : irq_timer_n;

  a_r6_stop_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |-> !set_tick);
  a_r6_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |=> (six_phase == '0));
  a_r5_tick_ends_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (div_tick && run) |=> (six_phase == '0));
  a_r7_test_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |=> (six_phase == '0));
endmodule

// File: tb/xtal_prescaler_bench.sv
module xtal_prescaler_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_en = 1'b0, osc_lvl = 1'b0, clk_stop = 1'b0, test_mode = 1'b0;
  logic irq_armed = 1'b0, irq_timer_n = 1'b1;
  logic set_tick, set_pulse, irq_pin_n;
  logic [2:0] six_phase;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int k = 0;
  int ticks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xtal_prescaler u_xtal_prescaler (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .osc_lvl(osc_lvl),
    .clk_stop(clk_stop), .test_mode(test_mode), .irq_armed(irq_armed),
    .irq_timer_n(irq_timer_n), .set_tick(set_tick), .set_pulse(set_pulse),
    .six_phase(six_phase), .irq_pin_n(irq_pin_n));

  function automatic int passed(input int n);
    return n - n / 16;
  endfunction

  function automatic logic [2:0] ring_at(input int p);
    case ((p / 512) % 6)
      0: return 3'b000;
      1: return 3'b001;
      2: return 3'b011;
      3: return 3'b111;
      4: return 3'b110;
      default: return 3'b100;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at k=%0d", req, act, exp, k);
    end
  endtask

  // One normal-mode cycle; en selects whether an oscillator enable arrives.
  task automatic run_cycle(input bit en);
    int kn;
    bit exp_tick;
    @(negedge clk);
    osc_en = en;
    #1;
    kn = en ? k + 1 : k;
    exp_tick = en && (kn % 16 != 0) && (passed(kn) % 3072 == 0);
    check(six_phase == ring_at(passed(k)), "R3/R4 phase", six_phase, ring_at(passed(k)));
    check(set_tick == exp_tick, "R5 tick", set_tick, exp_tick);
    check(set_pulse == (ring_at(passed(k)) == 3'b100), "R5 pulse", set_pulse,
          ring_at(passed(k)) == 3'b100);
    if (set_tick) ticks++;
    k = kn;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(six_phase == 3'b000, "R1 phase", six_phase, 0);
    check(set_tick == 1'b0 && set_pulse == 1'b0, "R1 outputs", set_tick, 0);

    // R2/R3/R4/R5: full 32768-enable run with a continuous enable
    k = 0; ticks = 0;
    for (int i = 0; i < 32768; i++) run_cycle(1'b1);
    check(ticks == 10, "R2 ticks per 32768", ticks, 10);

    // Gapped enables continue the same count
    for (int i = 0; i < 4000; i++) run_cycle(i % 3 == 0);

    // R6: stop mid-chain
    @(negedge clk); clk_stop = 1'b1; osc_en = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); osc_en = 1'b1; #1;
      check(set_tick == 1'b0, "R6 no tick while stopped", set_tick, 0);
      check(set_pulse == 1'b0, "R6 no pulse while stopped", set_pulse, 0);
    end
    @(negedge clk); osc_en = 1'b0; #1;
    check(six_phase == 3'b000, "R6 cleared", six_phase, 0);
    clk_stop = 1'b0;
    k = 0; ticks = 0;
    for (int i = 0; i < 3300; i++) run_cycle(1'b1);
    check(ticks == 1, "R6 restart first tick at 3276", ticks, 1);

    // R7: test mode fast ticks, chain frozen
    @(negedge clk); osc_en = 1'b0; test_mode = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); osc_en = (i % 2 == 0); #1;
      check(set_tick == osc_en, "R7 fast tick", set_tick, osc_en);
      check(six_phase == 3'b000, "R7 chain frozen", six_phase, 0);
    end
    @(negedge clk); clk_stop = 1'b1; osc_en = 1'b1; #1;
    check(set_tick == 1'b0, "R7 test and stop", set_tick, 0);

    // R8: interrupt pin routing, all combinations
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      test_mode = c[0]; irq_armed = c[1]; osc_lvl = c[2]; irq_timer_n = c[3];
      #1;
      check(irq_pin_n == ((c[0] && !c[1]) ? c[2] : c[3]), "R8 irq pin", irq_pin_n,
            (c[0] && !c[1]) ? c[2] : c[3]);
    end
    done = 1;
  end

  always @(posedge clk) begin
    cycles++;
    if (done || cycles > 190000) begin
      if (!done) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule